// File: doc/BRIEF.md
# Debug Memory Write Engine

This block is a small bus master that writes system memory on behalf of an external debug tool. The tool programs three registers through a narrow indexed register port: a target address, a control/status word and a write-data word. A write to the data register while the control word holds an armed write launches one bus write of that data to the programmed address. The tool then polls a data-valid flag and an error flag through the same port to learn when the engine is ready for the next word.

A count of zero or one gives a single write. A larger count gives a non-burst block: every data-register write sends one word, and each clean completion steps the address by the access size and lowers the count, until the final word disarms the engine. Size encodings that are not legal, addresses not aligned to the size, and error responses from the bus all raise the error flag. After an error no further write is launched until the tool rewrites the control word.

The control unit has three states. IDLE goes to REQ on an armed data write whose size and alignment are legal. REQ raises the bus request and goes to XFER when the grant arrives. XFER holds the request and returns to IDLE on an acknowledge (clean completion) or on an error response (failed completion). An armed write with an illegal size or alignment does not leave IDLE.

Top module: `dbg_wr_engine`

## Requirements
- R1: Register index 0x7 selects the control word, 0x9 the address and 0xA the data. Control layout: bit 31 start, bits 30:28 map select, bits 27:26 priority, bit 25 write (1 = write), bits 24:22 size, bits 21:6 count, bits 5:2 read as zero, bit 1 ERR, bit 0 DV. ERR and DV cannot be written. Other indices read as zero and writes to them change nothing.
- R2: After reset all three registers read zero and bus_req is low.
- R3: A data-register write with start=1, write=1, ERR=0 and the engine idle sets DV. On the next cycle bus_req is high with bus_addr, bus_wdata and bus_size (size bits 1:0) taken from the registers.
- R4: bus_req stays high and its address and data stay stable until bus_ack or bus_err. A clean bus_ack clears DV.
- R5: With a count of 0 or 1 one transfer is made. After it the count reads 0, start reads 0 and the address is unchanged.
- R6: With a count of 2 or more, each clean transfer adds 1, 2 or 4 (sizes 000, 001, 010) to the address and lowers the count by one. The next data write launches the next word.
- R7: Size codes 011 to 111 set ERR and DV on an armed data write and raise no bus request.
- R8: A 16-bit access at an odd address, or a 32-bit access with address bits 1:0 not zero, sets ERR and DV, raises no bus request and leaves count and address unchanged.
- R9: A bus_err response sets ERR, keeps DV at 1 and leaves count and address unchanged. Later data writes launch nothing until the control word is rewritten, which clears ERR and DV.
- R10: A data write with start=0 or write=0 stores the data but sets no DV and raises no request.
- R11: Register writes arriving while the engine is in REQ or XFER are ignored, including a write in the same cycle as the completing bus_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register port write strobe |
| reg_idx | input | 4 | Register index for read and write |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Register read value for reg_idx |
| bus_req | output | 1 | Bus request, held until completion |
| bus_gnt | input | 1 | Bus grant |
| bus_addr | output | ADDR_W | Write address |
| bus_wdata | output | 32 | Write data |
| bus_size | output | 2 | Access size: 0 byte, 1 half, 2 word |
| bus_ack | input | 1 | Clean completion |
| bus_err | input | 1 | Error completion |

## Verification
A register write and the end of a bus transfer can land on the same edge. The update that follows the acknowledge (DV clear, address step, count decrement) must win, and the port write must be dropped. The bench provokes this by raising bus_ack and an address-register write in the same cycle while the engine is in XFER. It then judges the outcome by reading back the unchanged address and the cleared DV. A write made during REQ, before grant, is checked the same way.

// File: rtl/dbgw_pkg.sv
package dbgw_pkg;

    localparam int REG_W = 32;
    localparam int CNT_W = 16;
    localparam int IDX_W = 4;

    localparam logic [IDX_W-1:0] IDX_CTL = 4'h7;
    localparam logic [IDX_W-1:0] IDX_ADR = 4'h9;
    localparam logic [IDX_W-1:0] IDX_DAT = 4'hA;

    localparam logic [2:0] SZ_BYTE = 3'b000;
    localparam logic [2:0] SZ_HALF = 3'b001;
    localparam logic [2:0] SZ_WORD = 3'b010;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic             start;
        logic [2:0]       map;
        logic [1:0]       prio;
        logic             wr;
        logic [2:0]       size;
        logic [CNT_W-1:0] cnt;
        logic [3:0]       rsvd;
        logic             err;
        logic             dv;
    } ctl_word_t;

endpackage

// File: rtl/dbgw_size_dec.sv
module dbgw_size_dec
    import dbgw_pkg::*;
(
    input  logic [2:0] size,
    input  logic [1:0] addr_lo,
    output logic       cfg_ok,
    output logic [2:0] step
);
    logic legal;
    logic aligned;

    always_comb begin
        legal   = 1'b1;
        aligned = 1'b1;
        step    = 3'd0;
        unique case (size)
            SZ_BYTE: step = 3'd1;
            SZ_HALF: begin
                step    = 3'd2;
                aligned = ~addr_lo[0];
            end
            SZ_WORD: begin
                step    = 3'd4;
                aligned = (addr_lo == 2'b00);
            end
            default: legal = 1'b0;
        endcase
        cfg_ok = legal & aligned;
    end
endmodule

// File: rtl/dbgw_fsm.sv
module dbgw_fsm
    import dbgw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       launch,
    input  logic       cfg_ok,
    input  logic       bus_gnt,
    input  logic       bus_ack,
    input  logic       bus_err,
    output eng_state_e state,
    output logic       bus_req,
    output logic       done_ok,
    output logic       done_err,
    output logic       chk_fail
);
    eng_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (launch && cfg_ok)      nxt = ST_REQ;
            ST_REQ:  if (bus_gnt)               nxt = ST_XFER;
            ST_XFER: if (bus_ack || bus_err)    nxt = ST_IDLE;
            default:                            nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        bus_req  = (state != ST_IDLE);
        done_ok  = (state == ST_XFER) && bus_ack && !bus_err;
        done_err = (state == ST_XFER) && bus_err;
        chk_fail = (state == ST_IDLE) && launch && !cfg_ok;
    end
endmodule

// File: rtl/dbg_wr_engine.sv
module dbg_wr_engine
    import dbgw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [REG_W-1:0]  bus_wdata,
    output logic [1:0]        bus_size,
    input  logic              bus_ack,
    input  logic              bus_err
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_TWO = CNT_W'(2);

    ctl_word_t         ctl_q;
    ctl_word_t         wr_ctl;
    logic [ADDR_W-1:0] addr_q;
    logic [REG_W-1:0]  data_q;
    logic              dv_q;
    logic              err_q;

    eng_state_e        state;
    logic              wr_ok;
    logic              armed;
    logic              launch;
    logic              cfg_ok;
    logic [2:0]        step;
    logic              done_ok;
    logic              done_err;
    logic              chk_fail;

    assign wr_ok  = reg_wr_en && (state == ST_IDLE);
    assign armed  = ctl_q.start && ctl_q.wr && !err_q;
    assign launch = wr_ok && (reg_idx == IDX_DAT) && armed;

    always_comb begin
        wr_ctl      = ctl_word_t'(reg_wdata);
        wr_ctl.rsvd = '0;
        wr_ctl.err  = 1'b0;
        wr_ctl.dv   = 1'b0;
    end

    dbgw_size_dec u_dec (
        .size    (ctl_q.size),
        .addr_lo (addr_q[1:0]),
        .cfg_ok  (cfg_ok),
        .step    (step)
    );

    dbgw_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .cfg_ok   (cfg_ok),
        .bus_gnt  (bus_gnt),
        .bus_ack  (bus_ack),
        .bus_err  (bus_err),
        .state    (state),
        .bus_req  (bus_req),
        .done_ok  (done_ok),
        .done_err (done_err),
        .chk_fail (chk_fail)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
            dv_q   <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (wr_ok && reg_idx == IDX_CTL) begin
                ctl_q <= wr_ctl;
                dv_q  <= 1'b0;
                err_q <= 1'b0;
            end
            if (wr_ok && reg_idx == IDX_ADR) addr_q <= reg_wdata[ADDR_W-1:0];
            if (wr_ok && reg_idx == IDX_DAT) begin
                data_q <= reg_wdata;
                if (armed) dv_q <= 1'b1;
            end
            if (chk_fail || done_err) err_q <= 1'b1;
            if (done_ok) begin
                dv_q <= 1'b0;
                if (ctl_q.cnt >= CNT_TWO) begin
                    addr_q    <= addr_q + ADDR_W'(step);
                    ctl_q.cnt <= ctl_q.cnt - CNT_ONE;
                end else begin
                    ctl_q.cnt   <= '0;
                    ctl_q.start <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_idx)
            IDX_CTL: begin
                reg_rdata    = REG_W'(ctl_q);
                reg_rdata[1] = err_q;
                reg_rdata[0] = dv_q;
            end
            IDX_ADR: reg_rdata = REG_W'(addr_q);
            IDX_DAT: reg_rdata = data_q;
            default: reg_rdata = '0;
        endcase
    end

    assign bus_addr  = addr_q;
    assign bus_wdata = data_q;
    assign bus_size  = ctl_q.size[1:0];
endmodule

// File: rtl/dbgw_checker.sv
module dbgw_checker
    import dbgw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_ack,
    input logic              bus_err,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic [1:0]        bus_size,
    input logic              dv_q,
    input logic              err_q,
    input logic              start_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [ADDR_W-1:0] addr_q
);
    // R4: request held with stable payload until completion
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && !bus_err) |=> (bus_req && $stable(bus_addr) && $stable(bus_wdata)));

    // R4: clean completion clears DV
    assert_ack_clears_dv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && !bus_err) |=> !dv_q);

    // R9: error response leaves ERR and DV set, count unchanged
    assert_err_keeps_dv_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_err) |=> (err_q && dv_q && cnt_q == $past(cnt_q)));

    // R9: no request while an error is pending
    assert_err_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> !bus_req);

    // R6: block step on clean completion
    assert_block_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && !bus_err && cnt_q >= CNT_W'(2)) |=>
        (cnt_q == $past(cnt_q) - CNT_W'(1) &&
         addr_q == $past(addr_q) + (ADDR_W'(1) << $past(bus_size))));

    // R5: single transfer disarms
    assert_single_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && !bus_err && cnt_q < CNT_W'(2)) |=>
        (cnt_q == '0 && !start_q && addr_q == $past(addr_q)));
endmodule

bind dbg_wr_engine dbgw_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack),
    .bus_err   (bus_err),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_size  (bus_size),
    .dv_q      (dv_q),
    .err_q     (err_q),
    .start_q   (ctl_q.start),
    .cnt_q     (ctl_q.cnt),
    .addr_q    (addr_q)
);

// File: tb/tb_dbg_wr_engine.sv
`timescale 1ns/1ps
module tb_dbg_wr_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_idx = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bus_req;
    logic        bus_gnt = 1'b0;
    logic [31:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [1:0]  bus_size;
    logic        bus_ack = 1'b0;
    logic        bus_err = 1'b0;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dbg_wr_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_size(bus_size), .bus_ack(bus_ack), .bus_err(bus_err)
    );

    localparam int NV = 7;
    localparam logic [31:0] V_ADDR [NV] = '{32'h1000, 32'h2001, 32'h3002, 32'h4000,
                                             32'h5002, 32'h6001, 32'h7000};
    localparam logic [2:0]  V_SIZE [NV] = '{3'd2, 3'd0, 3'd1, 3'd2, 3'd2, 3'd1, 3'd3};
    localparam logic [15:0] V_CNT  [NV] = '{16'd0, 16'd1, 16'd3, 16'd2, 16'd2, 16'd1, 16'd1};
    localparam logic        V_BAD  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ctl(logic st, logic wr, logic [2:0] sz, logic [15:0] cnt);
        return {st, 3'b000, 2'b00, wr, sz, cnt, 6'b000000};
    endfunction

    task automatic reg_write(logic [3:0] idx, logic [31:0] val);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_idx = idx; reg_wdata = val;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(logic [3:0] idx, output logic [31:0] val);
        reg_idx = idx;
        #0.5;
        val = reg_rdata;
    endtask

    task automatic serve(logic do_err, logic [31:0] ea, logic [31:0] ed, logic [1:0] es);
        logic [31:0] r;
        check("R3 bus_req", {31'd0, bus_req}, 32'd1);
        check("R3 bus_addr", bus_addr, ea);
        check("R3 bus_wdata", bus_wdata, ed);
        check("R3 bus_size", {30'd0, bus_size}, {30'd0, es});
        reg_read(4'h7, r);
        check("R3 dv set", {31'd0, r[0]}, 32'd1);
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        check("R4 req held", {31'd0, bus_req}, 32'd1);
        if (do_err) bus_err = 1'b1; else bus_ack = 1'b1;
        @(negedge clk);
        bus_err = 1'b0; bus_ack = 1'b0;
        check("R4 req dropped", {31'd0, bus_req}, 32'd0);
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        reg_read(4'h7, r); check("R2 ctl reset", r, 32'h0);
        reg_read(4'h9, r); check("R2 addr reset", r, 32'h0);
        reg_read(4'hA, r); check("R2 data reset", r, 32'h0);
        check("R2 req reset", {31'd0, bus_req}, 32'd0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            logic [31:0] step;
            int ntr;
            step = 32'd1 << V_SIZE[v][1:0];
            ntr  = (V_CNT[v] < 16'd2) ? 1 : int'(V_CNT[v]);
            reg_write(4'h9, V_ADDR[v]);
            reg_write(4'h7, mk_ctl(1'b1, 1'b1, V_SIZE[v], V_CNT[v]));
            if (V_BAD[v]) begin
                reg_write(4'hA, 32'hBAD0_0000 + v);
                @(negedge clk);
                check("R7 R8 no request", {31'd0, bus_req}, 32'd0);
                reg_read(4'h7, r);
                check("R7 R8 err", {31'd0, r[1]}, 32'd1);
                check("R7 R8 dv", {31'd0, r[0]}, 32'd1);
                check("R8 cnt kept", {16'd0, r[21:6]}, {16'd0, V_CNT[v]});
                reg_read(4'h9, r);
                check("R8 addr kept", r, V_ADDR[v]);
            end else begin
                for (int t = 0; t < ntr; t++) begin
                    reg_write(4'hA, 32'hD000_0000 + (v << 8) + t);
                    serve(1'b0, V_ADDR[v] + step * t, 32'hD000_0000 + (v << 8) + t, V_SIZE[v][1:0]);
                    reg_read(4'h7, r);
                    check("R4 dv cleared", {31'd0, r[0]}, 32'd0);
                    check("R6 err clear", {31'd0, r[1]}, 32'd0);
                    if (t < ntr - 1)
                        check("R6 count down", {16'd0, r[21:6]}, ntr - 1 - t);
                end
                reg_read(4'h7, r);
                check("R5 count zero", {16'd0, r[21:6]}, 32'd0);
                check("R5 start clear", {31'd0, r[31]}, 32'd0);
                reg_read(4'h9, r);
                check("R6 final addr", r, V_ADDR[v] + step * (ntr - 1));
            end
        end

        // R10 unarmed data write
        reg_write(4'h7, mk_ctl(1'b1, 1'b0, 3'd2, 16'd0));
        reg_write(4'hA, 32'hCAFE_0001);
        @(negedge clk);
        check("R10 no request", {31'd0, bus_req}, 32'd0);
        reg_read(4'h7, r); check("R10 no dv", {31'd0, r[0]}, 32'd0);
        reg_read(4'hA, r); check("R10 data stored", r, 32'hCAFE_0001);

        // R1 status bits not writable, unmapped index ignored
        reg_write(4'h7, mk_ctl(1'b0, 1'b1, 3'd1, 16'd5) | 32'h3F);
        reg_read(4'h7, r); check("R1 ctl readback", r, mk_ctl(1'b0, 1'b1, 3'd1, 16'd5));
        reg_write(4'h9, 32'h0000_1230);
        reg_write(4'h3, 32'hFFFF_FFFF);
        reg_read(4'h3, r); check("R1 unmapped reads zero", r, 32'h0);
        reg_read(4'h9, r); check("R1 addr untouched", r, 32'h0000_1230);

        // R9 bus error in block
        reg_write(4'h9, 32'h8000);
        reg_write(4'h7, mk_ctl(1'b1, 1'b1, 3'd2, 16'd3));
        reg_write(4'hA, 32'hE000_0001);
        serve(1'b1, 32'h8000, 32'hE000_0001, 2'd2);
        reg_read(4'h7, r);
        check("R9 err set", {31'd0, r[1]}, 32'd1);
        check("R9 dv kept", {31'd0, r[0]}, 32'd1);
        check("R9 cnt kept", {16'd0, r[21:6]}, 32'd3);
        reg_read(4'h9, r); check("R9 addr kept", r, 32'h8000);
        reg_write(4'hA, 32'hE000_0002);
        @(negedge clk);
        check("R9 blocked", {31'd0, bus_req}, 32'd0);
        reg_write(4'h7, mk_ctl(1'b1, 1'b1, 3'd2, 16'd3));
        reg_read(4'h7, r);
        check("R9 rewrite clears", {30'd0, r[1:0]}, 32'd0);
        reg_write(4'hA, 32'hE000_0003);
        serve(1'b0, 32'h8000, 32'hE000_0003, 2'd2);

        // R11 write during REQ ignored
        reg_write(4'h9, 32'h9000);
        reg_write(4'h7, mk_ctl(1'b1, 1'b1, 3'd2, 16'd0));
        reg_write(4'hA, 32'hF000_0001);
        reg_write(4'h9, 32'h1234_5678);
        serve(1'b0, 32'h9000, 32'hF000_0001, 2'd2);
        reg_read(4'h9, r); check("R11 write in REQ ignored", r, 32'h9000);

        // R11 write in the ack cycle ignored
        reg_write(4'h9, 32'hA000);
        reg_write(4'h7, mk_ctl(1'b1, 1'b1, 3'd0, 16'd0));
        reg_write(4'hA, 32'hF000_0002);
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        bus_ack = 1'b1;
        reg_wr_en = 1'b1; reg_idx = 4'h9; reg_wdata = 32'h0000_BEEF;
        @(negedge clk);
        bus_ack = 1'b0; reg_wr_en = 1'b0;
        reg_read(4'h9, r); check("R11 write on ack ignored", r, 32'hA000);
        reg_read(4'h7, r); check("R4 dv cleared on ack", {31'd0, r[0]}, 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule